// File: doc/BRIEF.md
# Microsecond System Timer

A small register-mapped timer peripheral for a 32-bit word bus. A prescaler divides the core clock down to a single-cycle 1 MHz tick. On each tick, a 64-bit free-running counter advances. Software reads the counter as two 32-bit words. Reading the low word first keeps the pair coherent, because that read captures the high word into a shadow register.

Four 32-bit compare registers watch the low counter word. When a tick makes the new low word equal to compare register n, status bit n is latched. Software clears status bits by writing ones to them. The interrupt output is high whenever any status bit is set.

Accesses are whole aligned words, selected by a 3-bit word address:

| Word address | Register |
|---|---|
| 0 | status |
| 1 | counter low word |
| 2 | counter high word |
| 3 to 6 | compare 0 to 3 |
| 7 | unmapped |

Top module: `ustimer`

## Requirements
- R1: After reset, the status register, all four compare registers, the counter and the prescaler are zero, and `irq` is low.
- R2: The counter advances by one every DIV core clocks. After the k-th rising edge since reset release, the counter holds floor(k/DIV). A read of word 1 accepted at edge k returns the low word as it was before that edge, that is floor((k-1)/DIV).
- R3: A read of word 1 captures counter bits 63:32 into a shadow register. A read of word 2 returns that shadow, which is zero until the first low-word read.
- R4: Writes to words 1 and 2 leave the counter unchanged, and `err` is high in the cycle after the write.
- R5: The compare registers at words 3 to 6 are read/write. Index n is the word address minus 3. Each read returns the last value written to it.
- R6: Status bit n is set on the tick at which the new counter low word equals compare register n. No other event sets it.
- R7: A write to word 0 clears exactly those status bits whose write-data bit is 1, and leaves the others unchanged.
- R8: When a compare match and a clearing write of the same bit happen on the same edge, the bit stays set.
- R9: `irq` is high exactly when at least one status bit is set. Status bits 31:4 read as zero.
- R10: A read of word 7 returns zero with `err` high in the next cycle. A write to word 7 raises `err` and changes no register.
- R11: Read data is registered. It appears in the cycle after `rd_en`, and `err` is a one-cycle pulse in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| err | output | 1 | Access error pulse |
| irq | output | 1 | Interrupt, OR of status bits |

## Verification
The bench runs with a small divider so that many ticks pass quickly. Counter reads at arbitrary phases of the prescaler show whether the counter moves on the correct edge and whether read data comes from the value before that edge.

Each compare channel is armed in turn with a value a few ticks ahead. The check requires that only that channel's bit sets. This separates a wrong channel index from a late or early match.

A clearing write is placed on the exact edge of a match to show that the event survives. A two-bit status word is partly cleared to tell a masked clear from a full clear. Read-back sweeps of the compare registers, and error accesses to the counter words and to the unmapped word, show that no other state moves.

// File: rtl/ustimer.sv
module ustimer #(
  parameter int DIV = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        err,
  output logic        irq
);
  localparam int NCMP = 4;
  localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [2:0] A_STS = 3'd0, A_LO = 3'd1, A_HI = 3'd2, A_CMP = 3'd3, A_BAD = 3'd7;

  logic [PW-1:0]   pre;
  logic [63:0]     cnt;
  logic [31:0]     shadow;
  logic [31:0]     cmp [NCMP];
  logic [NCMP-1:0] sts;
  logic [NCMP-1:0] hit;
  logic [31:0]     rd_mux;

  wire        tick   = (pre == PW'(DIV - 1));
  wire [63:0] cnt_nx = cnt + 64'd1;
  wire        sts_wr = wr_en && (addr == A_STS);
  wire        is_cmp = (addr >= A_CMP) && (addr < A_CMP + 3'(NCMP));
  wire [1:0]  cidx   = 2'(addr - A_CMP);

  assign irq = |sts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (tick) begin
      pre <= '0;
      cnt <= cnt_nx;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NCMP; gi++) begin : g_cmp
      assign hit[gi] = tick && (cnt_nx[31:0] == cmp[gi]);
      always_ff @(posedge clk) begin
        if (!rst_n)
          cmp[gi] <= '0;
        else if (wr_en && is_cmp && (cidx == 2'(gi)))
          cmp[gi] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)
      sts <= '0;
    else
      sts <= (sts & ~(sts_wr ? wdata[NCMP-1:0] : '0)) | hit;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_STS:   rd_mux = {{(32-NCMP){1'b0}}, sts};
      A_LO:    rd_mux = cnt[31:0];
      A_HI:    rd_mux = shadow;
      default: if (is_cmp) rd_mux = cmp[cidx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      shadow <= '0;
      err    <= 1'b0;
    end else begin
      err <= (rd_en && addr == A_BAD) ||
             (wr_en && (addr == A_LO || addr == A_HI || addr == A_BAD));
      if (rd_en) begin
        rdata <= rd_mux;
        if (addr == A_LO) shadow <= cnt[63:32];
      end
    end
  end
endmodule

module ustimer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [31:0] rdata,
  input logic        err,
  input logic        irq,
  input logic        tick,
  input logic [63:0] cnt
);
  // R11
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(rd_en || wr_en));
  // R10
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd7) |=> (rdata == 32'd0 && err));
  // R4
  ro_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 3'd1 || addr == 3'd2)) |=> err);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind ustimer ustimer_chk u_chk (.*);

// File: tb/ustimer_bench.sv
module ustimer_bench;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic err, irq;
  int tests = 0, fails = 0;
  int edges = 0;
  int cyc = 0;

  ustimer #(.DIV(DIV)) u_ustimer (.*);

  always #4 clk = ~clk;
  always @(posedge clk) begin
    if (rst_n) edges <= edges + 1;
    cyc <= cyc + 1;
  end

  initial begin
    wait (cyc == 100000);
    fails++;
    $display("FAIL watchdog: act=%0d exp<100000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output logic e);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; e = err;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic e, output int k);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0; d = rdata; e = err; k = edges;
  endtask

  task automatic wait_edges(input int n);
    while (edges < n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic e;
    int k, v;
    repeat (3) @(negedge clk);
    check("R1 irq", {31'd0, irq}, 0);
    rst_n = 1;
    rd(3'd0, d, e, k); check("R1 status", d, 0);
    for (int i = 0; i < 4; i++) begin
      rd(3'(3 + i), d, e, k); check("R1 compare", d, 0);
    end
    rd(3'd1, d, e, k); check("R1 counter", d, 32'((k - 1) / DIV));

    // R2 counter at various prescaler phases, R3 shadow
    for (int p = 0; p < 9; p++) begin
      repeat (p) @(negedge clk);
      rd(3'd1, d, e, k); check("R2 low word", d, 32'((k - 1) / DIV));
      rd(3'd2, d, e, k); check("R3 high shadow", d, 0);
    end

    // R4 writes to counter words
    wr(3'd1, 32'hFFFF_0000, e); check("R4 err lo", {31'd0, e}, 1);
    wr(3'd2, 32'h1234_5678, e); check("R4 err hi", {31'd0, e}, 1);
    rd(3'd1, d, e, k); check("R4 counter kept", d, 32'((k - 1) / DIV));
    check("R11 no err on good read", {31'd0, e}, 0);

    // R6 each channel alone, R7 clear, R9 irq
    for (int i = 0; i < 4; i++) begin
      v = edges / DIV + 3 + i;
      wr(3'(3 + i), 32'(v), e);
      wait_edges(v * DIV + 1);
      check("R9 irq set", {31'd0, irq}, 1);
      rd(3'd0, d, e, k); check("R6 single bit", d, 32'(1 << i));
      wr(3'd0, 32'(1 << i), e);
      rd(3'd0, d, e, k); check("R7 cleared", d, 0);
      check("R9 irq low", {31'd0, irq}, 0);
    end

    // R8 match and clear on same edge
    v = edges / DIV + 3;
    wr(3'd4, 32'(v), e);
    wait_edges(v * DIV - 1);
    wr(3'd0, 32'h2, e);
    rd(3'd0, d, e, k); check("R8 match wins", d, 32'h2);
    wr(3'd0, 32'hFFFF_FFFF, e);
    rd(3'd0, d, e, k); check("R9 upper zero", d, 0);

    // R7 partial clear
    v = edges / DIV + 3;
    wr(3'd3, 32'(v), e);
    wr(3'd5, 32'(v), e);
    wait_edges(v * DIV + 1);
    rd(3'd0, d, e, k); check("R6 two bits", d, 32'h5);
    wr(3'd0, 32'h4, e);
    rd(3'd0, d, e, k); check("R7 partial", d, 32'h1);
    check("R9 irq partial", {31'd0, irq}, 1);
    wr(3'd0, 32'h1, e);

    // R5 read-back sweep
    for (int pat = 0; pat < 4; pat++) begin
      for (int i = 0; i < 4; i++)
        wr(3'(3 + i), 32'hF000_0000 ^ (32'(pat) << 8) ^ 32'(i * 32'h0101_0101), e);
      for (int i = 0; i < 4; i++) begin
        rd(3'(3 + i), d, e, k);
        check("R5 readback", d, 32'hF000_0000 ^ (32'(pat) << 8) ^ 32'(i * 32'h0101_0101));
      end
    end

    // R10 unmapped
    rd(3'd7, d, e, k);
    check("R10 bad read data", d, 0);
    check("R10 bad read err", {31'd0, e}, 1);
    @(negedge clk);
    check("R11 err pulse", {31'd0, err}, 0);
    wr(3'd7, 32'hFFFF_FFFF, e); check("R10 bad write err", {31'd0, e}, 1);
    rd(3'd6, d, e, k); check("R10 compare untouched", d, 32'hF000_0300 ^ 32'h0303_0303);
    rd(3'd0, d, e, k); check("R10 status untouched", d, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule